// File: doc/BRIEF.md
# Nonvolatile Pseudo-SRAM Access Controller

This block sits between a synchronous host and a 128K x 8 ferroelectric memory with an asynchronous pseudo-SRAM pin interface. The host issues one read or write at a time through a request/ready handshake. The controller turns each request into a timed strobe sequence: an address setup phase, an active window with chip enable 1 low, a data hold phase, and a precharge phase. Read data comes back in a register with a one-cycle valid pulse.

The memory latches its address on the falling edge of chip enable 1. Each active window has both a minimum and a maximum length. Every access ends with chip enable 1 high for a precharge gap. All limits are given as picosecond parameters and are rounded up to whole clock cycles.

The derived cycle counts are as follows.
- N_AS: the address setup time, at least 1.
- N_ACC: the access time rounded up, plus 1.
- N_ACT: the largest of the active-minimum, write-pulse, address-hold, data-setup and N_ACC counts.
- N_HOLD: the larger of the data-hold and bus-float counts, at least 1.
- N_PRE: the larger of the precharge count and (cycle count − N_ACT − N_AS − 1), minus N_HOLD, at least 1.

Top module: `fram_psram_ctrl`

## Requirements
- R1: While reset is high and after it is released, with no request pending, these outputs hold: chip enable 1, write enable and output enable high (inactive), data drive enable low, and host ready high. Chip enable 2 is low during reset and high from the first clock after reset.
- R2: Host ready falls at the clock that accepts a request (request high while ready is high). It stays low for exactly N_AS+N_ACT+N_HOLD+N_PRE cycles. A request raised while ready is low starts no access.
- R3: The memory address changes only at acceptance. It is stable for N_AS cycles before chip enable 1 falls and for the whole time chip enable 1 is low.
- R4: Chip enable 1 stays low for exactly N_ACT cycles per access. This is at least the active minimum and never more than the active maximum.
- R5: Between accesses, chip enable 1 stays high for at least the precharge time. Falling edges of chip enable 1 are at least one full cycle time apart.
- R6: A write (read/write flag = 1) pulls write enable low in the same cycles as chip enable 1, so the pulse is at least the write-pulse minimum. Output enable stays high throughout the write.
- R7: Write data is driven from acceptance, at least the data setup time before write enable rises. It stays driven and unchanged for N_HOLD cycles after write enable rises.
- R8: A read (flag = 0) pulls output enable low together with chip enable 1 and leaves write enable high and the data bus undriven. Data is captured at the last active cycle, N_ACT ≥ N_ACC cycles after both enables became active.
- R9: Each read yields exactly one one-cycle valid pulse, with the captured byte, in the cycle chip enable 1 returns high. A write yields no valid pulse.
- R10: The data bus is not driven until at least the float time after output enable rises.
- R11: Write enable and output enable are never both low, and the data bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Ready to accept a request |
| host_rdata | output | DATA_W | Captured read data |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_ce1_n | output | 1 | Chip enable 1, active low |
| mem_ce2 | output | 1 | Chip enable 2, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_in | input | DATA_W | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The main access path is exercised with the byte values 00, FF, A5 and 5A at the lowest and highest addresses. These separate stuck or swapped data bits. A walking-one address sweep writes a distinct byte to each single-bit address and then reads all of them back. This exposes address bits that are dropped, swapped or latched at the wrong moment.

Back-to-back writes and reads with no host idle time check the precharge and cycle-time limits at their tightest. A behavioural memory model returns a garbage byte until the access time has elapsed, so a capture taken too early shows up as a data mismatch. A request held high while the controller is busy, followed by a read-back, separates a correctly ignored request from a spurious extra access.

// File: rtl/fram_ctrl_pkg.sv
`timescale 1ns/1ps
package fram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_PRE
  } seq_state_t;

  // Round a picosecond limit up to whole clock cycles.
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fram_dwell_timer.sv
`timescale 1ns/1ps
module fram_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  // A load of N makes done rise after N-1 cycles, so the owning state lasts N cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/fram_strobe_seq.sv
`timescale 1ns/1ps
module fram_strobe_seq
  import fram_ctrl_pkg::*;
#(
  parameter int N_AS   = 1,
  parameter int N_ACT  = 21,
  parameter int N_HOLD = 5,
  parameter int N_PRE  = 1,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             rw,
  input  logic             tmr_done,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sample,
  output logic             ready,
  output logic             ce1_n,
  output logic             ce2,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  seq_state_t state;
  logic       wr_q;

  assign accept = (state == ST_IDLE) && req;
  assign sample = (state == ST_ACTIVE) && tmr_done && !wr_q;

  // The dwell for the next phase is loaded on the edge that enters it.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        tmr_load = accept;
        tmr_val  = CNT_W'(N_AS);
      end
      ST_SETUP: begin
        tmr_load = tmr_done;
        tmr_val  = CNT_W'(N_ACT);
      end
      ST_ACTIVE: begin
        tmr_load = tmr_done;
        tmr_val  = CNT_W'(N_HOLD);
      end
      ST_HOLD: begin
        tmr_load = tmr_done;
        tmr_val  = CNT_W'(N_PRE);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wr_q  <= 1'b0;
      ready <= 1'b1;
      ce1_n <= 1'b1;
      ce2   <= 1'b0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce2 <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SETUP;
            ready <= 1'b0;
            wr_q  <= rw;
            dq_oe <= rw;
          end
        end
        ST_SETUP: begin
          if (tmr_done) begin
            state <= ST_ACTIVE;
            ce1_n <= 1'b0;
            we_n  <= !wr_q;
            oe_n  <= wr_q;
          end
        end
        ST_ACTIVE: begin
          if (tmr_done) begin
            state <= ST_HOLD;
            ce1_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (tmr_done) begin
            state <= ST_PRE;
            dq_oe <= 1'b0;
          end
        end
        ST_PRE: begin
          if (tmr_done) begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fram_io_regs.sv
`timescale 1ns/1ps
module fram_io_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      dq_out   <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= sample;
      if (sample) begin
        rdata <= dq_in;
      end
    end
  end

endmodule

// File: rtl/fram_psram_ctrl.sv
`timescale 1ns/1ps
module fram_psram_ctrl
  import fram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_AS_PS       = 10000,
  parameter int T_AH_PS       = 50000,
  parameter int T_CA_MIN_PS   = 210000,
  parameter int T_CA_MAX_PS   = 2000000,
  parameter int T_PC_PS       = 40000,
  parameter int T_CYC_PS      = 250000,
  parameter int T_WP_PS       = 210000,
  parameter int T_DS_PS       = 10000,
  parameter int T_DH_PS       = 50000,
  parameter int T_ACC_PS      = 100000,
  parameter int T_HZ_PS       = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int N_AS    = imax(1, cyc_of(T_AS_PS, CLK_PERIOD_PS));
  localparam int N_ACC   = cyc_of(T_ACC_PS, CLK_PERIOD_PS) + 1;
  localparam int N_ACT   = imax(imax(cyc_of(T_CA_MIN_PS, CLK_PERIOD_PS),
                                     cyc_of(T_WP_PS, CLK_PERIOD_PS)),
                                imax(N_ACC,
                                     imax(cyc_of(T_AH_PS, CLK_PERIOD_PS),
                                          cyc_of(T_DS_PS, CLK_PERIOD_PS))));
  localparam int N_HOLD  = imax(1, imax(cyc_of(T_DH_PS, CLK_PERIOD_PS),
                                        cyc_of(T_HZ_PS, CLK_PERIOD_PS)));
  localparam int N_REC   = imax(cyc_of(T_PC_PS, CLK_PERIOD_PS),
                                cyc_of(T_CYC_PS, CLK_PERIOD_PS) - N_ACT - N_AS - 1);
  localparam int N_PRE   = imax(1, N_REC - N_HOLD);
  localparam int N_LIMIT = T_CA_MAX_PS / CLK_PERIOD_PS;
  localparam int CNT_W   = $clog2(imax(imax(N_ACT, N_HOLD), imax(N_AS, N_PRE)) + 1);

  if (N_ACT > N_LIMIT) begin : g_window_too_long
    $error("active window of %0d cycles exceeds the %0d-cycle upper bound", N_ACT, N_LIMIT);
  end

  logic             accept;
  logic             sample;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_val;

  fram_dwell_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  fram_strobe_seq #(
    .N_AS   (N_AS),
    .N_ACT  (N_ACT),
    .N_HOLD (N_HOLD),
    .N_PRE  (N_PRE),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (host_req),
    .rw       (host_we),
    .tmr_done (tmr_done),
    .accept   (accept),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .sample   (sample),
    .ready    (host_ready),
    .ce1_n    (mem_ce1_n),
    .ce2      (mem_ce2),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe)
  );

  fram_io_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .sample     (sample),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .dq_in      (mem_dq_in),
    .mem_addr   (mem_addr),
    .dq_out     (mem_dq_out),
    .rdata      (host_rdata),
    .rvalid     (host_rvalid)
  );

endmodule

// File: rtl/fram_ctrl_chk.sv
`timescale 1ns/1ps
module fram_ctrl_chk #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_CA_MIN_PS   = 210000,
  parameter int T_CA_MAX_PS   = 2000000
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int MAX_LOW = T_CA_MAX_PS / CLK_PERIOD_PS;
  localparam int MIN_LOW = (T_CA_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int LR_W    = $clog2(MAX_LOW + 2) + 1;

  logic [LR_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || mem_ce1_n) begin
      low_run <= '0;
    end else begin
      low_run <= low_run + 1'b1;
    end
  end

  AST_CE2_ON: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mem_ce2) else $error("chip enable 2 low after reset"); // R1

  AST_BUSY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |-> !host_ready) else $error("ready high during active window"); // R2

  AST_ADDR_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce1_n) |-> $stable(mem_addr)) else $error("address moved at enable fall"); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && !$fell(mem_ce1_n)) |-> $stable(mem_addr)) else $error("address moved in window"); // R3

  AST_WINDOW_MAX: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |-> (low_run < LR_W'(MAX_LOW))) else $error("active window too long"); // R4

  AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce1_n) |-> (low_run >= LR_W'(MIN_LOW))) else $error("active window too short"); // R4

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce1_n) else $error("write enable outside window"); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out))) else $error("write data not held"); // R7

  AST_RVALID_AT_END: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> ($rose(mem_ce1_n) && $past(!mem_oe_n))) else $error("read valid misplaced"); // R9

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid) else $error("read valid longer than one cycle"); // R9

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n)) else $error("write and output enable both low"); // R11

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n) else $error("bus driven with output enable low"); // R11

endmodule

bind fram_psram_ctrl fram_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_CA_MIN_PS   (T_CA_MIN_PS),
  .T_CA_MAX_PS   (T_CA_MAX_PS)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_ce1_n   (mem_ce1_n),
  .mem_ce2     (mem_ce2),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_addr    (mem_addr),
  .mem_dq_out  (mem_dq_out),
  .mem_dq_oe   (mem_dq_oe)
);

// File: tb/test_fram_psram_ctrl.sv
`timescale 1ns/1ps
module test_fram_psram_ctrl;

  localparam int CLK_PS = 4000;
  localparam int AW     = 17;
  localparam int DW     = 8;

  function automatic int up(input int t_ps);
    return (t_ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected cycle counts from the requirement formulas.
  localparam int E_AS   = mx(1, up(10000));
  localparam int E_ACT  = mx(mx(up(210000), up(210000)), mx(up(100000) + 1, mx(up(50000), up(10000))));
  localparam int E_HOLD = mx(1, mx(up(50000), up(25000)));
  localparam int E_PRE  = mx(1, mx(up(40000), up(250000) - E_ACT - E_AS - 1) - E_HOLD);
  localparam int E_BUSY = E_AS + E_ACT + E_HOLD + E_PRE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ready;
  logic [DW-1:0] host_rdata;
  logic          host_rvalid;
  logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hEE;

  int n_checks = 0;
  int n_errs   = 0;

  always #2 clk = ~clk;

  fram_psram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .CLK_PERIOD_PS (CLK_PS)
  ) i_fram_psram_ctrl (
    .clk (clk), .rst (rst),
    .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_ready (host_ready),
    .host_rdata (host_rdata), .host_rvalid (host_rvalid),
    .mem_ce1_n (mem_ce1_n), .mem_ce2 (mem_ce2), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_addr (mem_addr), .mem_dq_out (mem_dq_out),
    .mem_dq_in (mem_dq_in), .mem_dq_oe (mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [int];
  logic [AW-1:0] lat_addr = '0;
  realtime t_addr = -1000.0, t_fall = -1000.0, t_rise = -1000.0;
  realtime t_wef = -1000.0, t_wer = -1000.0, t_dq = -1000.0;
  realtime t_oef = -1000.0, t_oer = -1000.0;
  int n_falls = 0;
  int n_clash = 0;

  always @(mem_addr) begin
    if (!rst && !mem_ce1_n)
      chk($realtime - t_fall >= 50.0, "R3", "address hold ns", longint'($realtime - t_fall), 50);
    t_addr = $realtime;
  end

  always @(negedge mem_ce1_n) begin
    if (mem_ce2) begin
      chk($realtime - t_addr >= 10.0, "R3", "address setup ns", longint'($realtime - t_addr), 10);
      chk($realtime - t_rise >= 40.0, "R5", "precharge ns", longint'($realtime - t_rise), 40);
      chk($realtime - t_fall >= 250.0, "R5", "cycle ns", longint'($realtime - t_fall), 250);
      t_fall   = $realtime;
      lat_addr = mem_addr;
      n_falls++;
    end
  end

  always @(posedge mem_ce1_n) begin
    if (!rst) begin
      chk(($realtime - t_fall >= 210.0) && ($realtime - t_fall <= 2000.0), "R4",
          "active ns", longint'($realtime - t_fall), 210);
      t_rise = $realtime;
    end
  end

  always @(negedge mem_we_n) t_wef = $realtime;

  always @(posedge mem_we_n) begin
    if (!rst) begin
      chk($realtime - t_wef >= 210.0, "R6", "write pulse ns", longint'($realtime - t_wef), 210);
      chk(mem_dq_oe && ($realtime - t_dq >= 10.0), "R7", "data setup ns", longint'($realtime - t_dq), 10);
      mem[int'(lat_addr)] = mem_dq_out;
      t_wer = $realtime;
    end
  end

  always @(mem_dq_out or mem_dq_oe) begin
    if (!rst && ($realtime - t_wer < 50.0))
      chk(1'b0, "R7", "data hold ns", longint'($realtime - t_wer), 50);
    t_dq = $realtime;
  end

  always @(negedge mem_oe_n) t_oef = $realtime;
  always @(posedge mem_oe_n) t_oer = $realtime;

  // Model output, updated on half-nanosecond ticks away from clock edges.
  initial begin
    #0.5;
    forever begin
      logic drv;
      drv = (!mem_ce1_n && !mem_oe_n) || ($realtime - t_oer < 25.0);
      if (!mem_ce1_n && mem_ce2 && !mem_oe_n &&
          ($realtime - t_fall >= 100.0) && ($realtime - t_oef >= 100.0))
        mem_dq_in = mem.exists(int'(lat_addr)) ? mem[int'(lat_addr)] : 8'h00;
      else
        mem_dq_in = 8'hEE;
      if (drv && mem_dq_oe) n_clash++;
      #1;
    end
  end

  // ---------------- cycle monitor ----------------
  int low_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce1_n) low_run++;
      else if (low_run != 0) begin
        chk(low_run == E_ACT, "R4", "active cycles", low_run, E_ACT);
        low_run = 0;
      end
      if (!mem_we_n || !mem_oe_n)
        chk(!(!mem_we_n && !mem_oe_n), "R11", "we/oe both low", 1, 0);
      if (!mem_oe_n)
        chk(mem_we_n && !mem_dq_oe, "R8", "read strobes", {mem_we_n, mem_dq_oe}, 2);
      if (!mem_we_n)
        chk(mem_oe_n && !mem_ce1_n, "R6", "write strobes", {mem_oe_n, mem_ce1_n}, 2);
    end
  end

  // ---------------- host access task ----------------
  task automatic host_op(input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
    int busy;
    int rv;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    busy = 0; rv = 0; rd = 'x;
    while (!host_ready) begin
      busy++;
      if (host_rvalid) begin rv++; rd = host_rdata; end
      @(negedge clk);
    end
    if (host_rvalid) begin rv++; rd = host_rdata; end
    chk(busy == E_BUSY, "R2", "busy cycles", busy, E_BUSY);
    chk(rv == (we ? 0 : 1), "R9", "valid pulses", rv, we ? 0 : 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] unused_rd;
    host_op(1'b1, a, d, unused_rd);
  endtask

  task automatic do_read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] rd;
    host_op(1'b0, a, 8'h00, rd);
    chk(rd === exp, req, "read data", rd, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state;
    chk(mem_ce1_n && mem_we_n && mem_oe_n && !mem_dq_oe && host_ready && !mem_ce2,
        "R1", "outputs in reset", {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready, mem_ce2}, 6'b111010);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(mem_ce1_n && mem_we_n && mem_oe_n && !mem_dq_oe && host_ready && mem_ce2,
        "R1", "outputs after reset", {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready, mem_ce2}, 6'b111011);
  endtask

  task automatic t_patterns;
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'h5A);
    do_write(17'h00001, 8'h00);
    do_write(17'h1FFFE, 8'hFF);
    do_read_chk(17'h00000, 8'hA5, "R8");
    do_read_chk(17'h1FFFF, 8'h5A, "R8");
    do_read_chk(17'h00001, 8'h00, "R7");
    do_read_chk(17'h1FFFE, 8'hFF, "R7");
  endtask

  task automatic t_addr_walk;
    for (int i = 0; i < AW; i++) do_write(AW'(1) << i, 8'(8'h11 + i));
    for (int i = 0; i < AW; i++) do_read_chk(AW'(1) << i, 8'(8'h11 + i), "R3");
  endtask

  task automatic t_busy_ignore;
    int falls0;
    logic [DW-1:0] rd;
    do_write(17'h00ABC, 8'h3C);
    falls0 = n_falls;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 17'h00ABC; host_wdata = 8'h77;
    @(negedge clk);
    host_req = 1'b0;
    // a second request while busy: raised for a few cycles then dropped
    repeat (5) @(negedge clk);
    host_req = 1'b1; host_addr = 17'h00ABC; host_wdata = 8'hC3;
    repeat (10) @(negedge clk);
    host_req = 1'b0;
    while (!host_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_falls == falls0 + 1, "R2", "accesses started", n_falls - falls0, 1);
    host_op(1'b0, 17'h00ABC, 8'h00, rd);
    chk(rd == 8'h77, "R2", "busy request ignored", rd, 8'h77);
  endtask

  task automatic t_turnaround;
    do_write(17'h00010, 8'h96);
    do_read_chk(17'h00010, 8'h96, "R10");
    do_write(17'h00011, 8'h69);
    do_read_chk(17'h00011, 8'h69, "R10");
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_patterns();
    t_addr_walk();
    t_busy_ignore();
    t_turnaround();
    repeat (20) @(negedge clk);
    chk(n_clash == 0, "R10", "bus contention ticks", n_clash, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule